// File: doc/BRIEF.md
# Superpage-Capable Translation Lookaside Buffer

This block is a fully associative address translation cache. Each slot maps either a single 8 KB base page or a 128 KB superpage: an aligned group of 16 consecutive base pages that share one slot and sit in contiguous physical frames. A lookup presents a virtual page number, the access kind (read or write) and the privilege level. In the same cycle, combinationally, the block returns a hit flag with the physical page number, or raises a protection fault when the slot's permission bits forbid the access.

Slots are filled through an install port. The victim is chosen by a round-robin pointer. Any older slot whose address range overlaps the incoming mapping is dropped in the same cycle, so a lookup never matches more than one slot. An invalidate port removes whichever slot covers a given virtual page. Walking the page table and deciding when to promote pages into superpages are left to the surrounding system.

Top module: `tlb_sp`

## Requirements
- R1: After reset every slot is invalid, and any lookup returns hit_o=0, fault_o=0 and ppn_o=0.
- R2: A base-page slot matches only when all VPN_W bits of the lookup page number equal its stored page number, and it then returns its stored physical page number.
- R3: A superpage slot (size flag 1) ignores the low SP_BITS=4 page-number bits in its compare, so it matches all 16 pages of its aligned group and nothing outside that group.
- R4: On a superpage hit, ppn_o is the slot's aligned physical base with the low 4 bits taken from vpn_i. An install with the size flag set ignores the low 4 bits of both ins_vpn_i and ins_ppn_i.
- R5: Permission bits are indexed by {user, write}: bit0 = kernel read, bit1 = kernel write, bit2 = user read, bit3 = user write. An access is allowed only when its bit is 1.
- R6: A matching lookup whose permission bit is 0 gives fault_o=1, hit_o=0 and ppn_o=0 in the same cycle. A lookup that matches no slot gives fault_o=0, hit_o=0 and ppn_o=0.
- R7: An install invalidates every valid slot whose range overlaps the new mapping. The overlap test compares at superpage granularity when either side is a superpage, and at full width otherwise. At most one slot ever matches a lookup.
- R8: Each install writes the slot at the round-robin pointer, whether that slot is valid or not. The pointer starts at 0 after reset, advances by one per install, and wraps from ENTRIES-1 to 0.
- R9: An invalidate request removes the slot that matches inv_vpn_i under the lookup rule, including a superpage covering that page. It leaves non-matching slots untouched.
- R10: While lookup_i is 0, hit_o, fault_o and ppn_o are all 0.
- R11: When install and invalidate occur in the same cycle, the invalidate acts on the existing slots and the newly installed slot is kept valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup request |
| vpn_i | input | VPN_W | Lookup virtual page number |
| user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| write_i | input | 1 | 1 = write access, 0 = read |
| hit_o | output | 1 | Permitted translation found |
| ppn_o | output | PPN_W | Translated physical page number, 0 unless hit_o |
| fault_o | output | 1 | Mapping found but access not permitted |
| ins_i | input | 1 | Install request |
| ins_vpn_i | input | VPN_W | Virtual page number to install |
| ins_ppn_i | input | PPN_W | Physical page number to install |
| ins_super_i | input | 1 | 1 = superpage mapping |
| ins_perm_i | input | 4 | Permission bits, encoded as in R5 |
| inv_i | input | 1 | Invalidate request |
| inv_vpn_i | input | VPN_W | Page whose covering slot is removed |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=19 and PPN_W=19. With only four slots, the round-robin pointer wraps after a handful of installs, so a test can observe eviction order, the reuse of an invalidated slot and the overlap purge without filling a large array. The full 19-bit page numbers keep the superpage group boundaries and the pass-through of the low translation bits at their real positions.

// File: rtl/tlb_sp_pkg.sv
`timescale 1ns/1ps
package tlb_sp_pkg;
  localparam int PERM_W = 4;
  typedef logic [PERM_W-1:0] perm_t;

  // bit index = {user, write}
  function automatic logic perm_ok(perm_t p, logic user, logic write);
    return p[{user, write}];
  endfunction
endpackage

// File: rtl/tlb_sp_cmp.sv
`timescale 1ns/1ps
module tlb_sp_cmp #(
  parameter int VPN_W   = 19,
  parameter int SP_BITS = 4
) (
  input  logic [VPN_W-1:0] a_i,
  input  logic [VPN_W-1:0] b_i,
  input  logic             coarse_i,
  input  logic             valid_i,
  output logic             eq_o
);
  logic hi_eq, lo_eq;
  assign hi_eq = (a_i[VPN_W-1:SP_BITS] == b_i[VPN_W-1:SP_BITS]);
  assign lo_eq = coarse_i | (a_i[SP_BITS-1:0] == b_i[SP_BITS-1:0]);
  assign eq_o  = valid_i & hi_eq & lo_eq;
endmodule

// File: rtl/tlb_sp_rr.sv
`timescale 1ns/1ps
module tlb_sp_rr #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_sp.sv
`timescale 1ns/1ps
module tlb_sp
  import tlb_sp_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 19,
  parameter int SP_BITS = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              user_i,
  input  logic              write_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              fault_o,
  input  logic              ins_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [PPN_W-1:0]  ins_ppn_i,
  input  logic              ins_super_i,
  input  logic [PERM_W-1:0] ins_perm_i,
  input  logic              inv_i,
  input  logic [VPN_W-1:0]  inv_vpn_i
);
  logic             v_q    [ENTRIES];
  logic             sp_q   [ENTRIES];
  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  perm_t            perm_q [ENTRIES];

  logic [ENTRIES-1:0] match_vec, inv_vec, ovl_vec;
  logic [IDX_W-1:0]   rr_ptr;

  // aligned copies written on install
  logic [VPN_W-1:0] ins_vpn_al;
  logic [PPN_W-1:0] ins_ppn_al;
  assign ins_vpn_al = ins_super_i ? {ins_vpn_i[VPN_W-1:SP_BITS], {SP_BITS{1'b0}}} : ins_vpn_i;
  assign ins_ppn_al = ins_super_i ? {ins_ppn_i[PPN_W-1:SP_BITS], {SP_BITS{1'b0}}} : ins_ppn_i;

  tlb_sp_rr #(.ENTRIES(ENTRIES)) i_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ins_i),
    .ptr_o (rr_ptr)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    tlb_sp_cmp #(.VPN_W(VPN_W), .SP_BITS(SP_BITS)) i_look (
      .a_i(vpn_i), .b_i(vpn_q[e]), .coarse_i(sp_q[e]),
      .valid_i(v_q[e]), .eq_o(match_vec[e])
    );
    tlb_sp_cmp #(.VPN_W(VPN_W), .SP_BITS(SP_BITS)) i_inv (
      .a_i(inv_vpn_i), .b_i(vpn_q[e]), .coarse_i(sp_q[e]),
      .valid_i(v_q[e]), .eq_o(inv_vec[e])
    );
    // overlap: coarse if either side is a superpage
    tlb_sp_cmp #(.VPN_W(VPN_W), .SP_BITS(SP_BITS)) i_ovl (
      .a_i(ins_vpn_i), .b_i(vpn_q[e]), .coarse_i(sp_q[e] | ins_super_i),
      .valid_i(v_q[e]), .eq_o(ovl_vec[e])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[e]    <= 1'b0;
        sp_q[e]   <= 1'b0;
        vpn_q[e]  <= '0;
        ppn_q[e]  <= '0;
        perm_q[e] <= '0;
      end else if (ins_i && (rr_ptr == IDX_W'(e))) begin
        v_q[e]    <= 1'b1;
        sp_q[e]   <= ins_super_i;
        vpn_q[e]  <= ins_vpn_al;
        ppn_q[e]  <= ins_ppn_al;
        perm_q[e] <= ins_perm_i;
      end else if ((ins_i && ovl_vec[e]) || (inv_i && inv_vec[e])) begin
        v_q[e] <= 1'b0;
      end
    end
  end

  // one-hot select by OR reduction
  logic             any_match, sel_sp;
  logic [PPN_W-1:0] sel_ppn;
  perm_t            sel_perm;

  always_comb begin
    any_match = 1'b0;
    sel_sp    = 1'b0;
    sel_ppn   = '0;
    sel_perm  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) begin
        any_match = 1'b1;
        sel_sp    = sel_sp | sp_q[e];
        sel_ppn   = sel_ppn | ppn_q[e];
        sel_perm  = sel_perm | perm_q[e];
      end
    end
  end

  logic allowed;
  assign allowed = perm_ok(sel_perm, user_i, write_i);
  assign hit_o   = lookup_i & any_match & allowed;
  assign fault_o = lookup_i & any_match & ~allowed;

  always_comb begin
    if (!hit_o)      ppn_o = '0;
    else if (sel_sp) ppn_o = {sel_ppn[PPN_W-1:SP_BITS], vpn_i[SP_BITS-1:0]};
    else             ppn_o = sel_ppn;
  end
endmodule

// File: rtl/tlb_sp_chk.sv
`timescale 1ns/1ps
module tlb_sp_chk #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 19,
  parameter int SP_BITS = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lookup_i,
  input logic [VPN_W-1:0]   vpn_i,
  input logic               ins_i,
  input logic               hit_o,
  input logic               fault_o,
  input logic [PPN_W-1:0]   ppn_o,
  input logic [ENTRIES-1:0] match_vec,
  input logic               sel_sp,
  input logic [IDX_W-1:0]   rr_ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // R6
  hit_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o));

  // R6
  miss_ppn_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ppn_o == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |-> (!hit_o && !fault_o));

  // R7
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R8
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> (rr_ptr == (($past(rr_ptr) == LAST) ? '0 : $past(rr_ptr) + 1'b1)));

  // R8
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_i |=> $stable(rr_ptr));

  // R4
  sp_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && sel_sp) |-> (ppn_o[SP_BITS-1:0] == vpn_i[SP_BITS-1:0]));
endmodule

bind tlb_sp tlb_sp_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .SP_BITS(SP_BITS)
) i_tlb_sp_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lookup_i (lookup_i),
  .vpn_i    (vpn_i),
  .ins_i    (ins_i),
  .hit_o    (hit_o),
  .fault_o  (fault_o),
  .ppn_o    (ppn_o),
  .match_vec(match_vec),
  .sel_sp   (sel_sp),
  .rr_ptr   (rr_ptr)
);

// File: tb/test_tlb_sp.sv
`timescale 1ns/1ps
module test_tlb_sp;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 19;
  localparam int PPN_W   = 19;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lookup_i = 1'b0;
  logic [VPN_W-1:0] vpn_i = '0;
  logic             user_i = 1'b0;
  logic             write_i = 1'b0;
  logic             hit_o, fault_o;
  logic [PPN_W-1:0] ppn_o;
  logic             ins_i = 1'b0;
  logic [VPN_W-1:0] ins_vpn_i = '0;
  logic [PPN_W-1:0] ins_ppn_i = '0;
  logic             ins_super_i = 1'b0;
  logic [3:0]       ins_perm_i = '0;
  logic             inv_i = 1'b0;
  logic [VPN_W-1:0] inv_vpn_i = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tlb_sp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_tlb_sp (.*);

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; ins_i = 0; inv_i = 0; lookup_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic install(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                         input logic sp, input logic [3:0] perm);
    @(negedge clk_i);
    ins_i = 1; ins_vpn_i = v; ins_ppn_i = p; ins_super_i = sp; ins_perm_i = perm;
    @(negedge clk_i);
    ins_i = 0;
  endtask

  task automatic invalidate(input logic [VPN_W-1:0] v);
    @(negedge clk_i);
    inv_i = 1; inv_vpn_i = v;
    @(negedge clk_i);
    inv_i = 0;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v, input logic u,
                      input logic w, input logic eh, input logic ef,
                      input logic [PPN_W-1:0] ep);
    @(negedge clk_i);
    lookup_i = 1; vpn_i = v; user_i = u; write_i = w;
    #1;
    n_run++;
    if (hit_o !== eh || fault_o !== ef || ppn_o !== ep) begin
      n_fail++;
      $display("FAIL %s vpn=%h: hit/fault/ppn got %b/%b/%h expected %b/%b/%h",
               req, v, hit_o, fault_o, ppn_o, eh, ef, ep);
    end
    lookup_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    look("R1", 19'h00010, 0, 0, 0, 0, '0);
    look("R1", 19'h00000, 1, 1, 0, 0, '0);
  endtask

  task automatic t_idle();
    do_reset();
    install(19'h00050, 19'h00077, 0, 4'hF);
    @(negedge clk_i);
    lookup_i = 0; vpn_i = 19'h00050;
    #1;
    n_run++;
    if (hit_o !== 0 || fault_o !== 0 || ppn_o !== '0) begin
      n_fail++;
      $display("FAIL R10 idle: got %b/%b/%h expected 0/0/0", hit_o, fault_o, ppn_o);
    end
  endtask

  task automatic t_base();
    do_reset();
    install(19'h00123, 19'h0ABCD, 0, 4'hF);
    look("R2", 19'h00123, 0, 0, 1, 0, 19'h0ABCD);
    look("R2", 19'h00124, 0, 0, 0, 0, '0);
    look("R2", 19'h00133, 0, 0, 0, 0, '0);
  endtask

  task automatic t_super();
    do_reset();
    install(19'h00345, 19'h07777, 1, 4'hF);
    look("R3", 19'h00340, 0, 0, 1, 0, 19'h07770);
    look("R4", 19'h0034F, 1, 0, 1, 0, 19'h0777F);
    look("R4", 19'h00345, 0, 1, 1, 0, 19'h07775);
    look("R3", 19'h00350, 0, 0, 0, 0, '0);
    look("R3", 19'h0033F, 0, 0, 0, 0, '0);
  endtask

  task automatic t_perm();
    do_reset();
    install(19'h01000, 19'h00200, 0, 4'b0111);
    look("R6", 19'h01000, 1, 1, 0, 1, '0);
    look("R5", 19'h01000, 1, 0, 1, 0, 19'h00200);
    look("R5", 19'h01000, 0, 1, 1, 0, 19'h00200);
    install(19'h01001, 19'h00300, 0, 4'b0001);
    look("R5", 19'h01001, 0, 0, 1, 0, 19'h00300);
    look("R6", 19'h01001, 0, 1, 0, 1, '0);
    look("R6", 19'h01001, 1, 0, 0, 1, '0);
    install(19'h01002, 19'h00400, 0, 4'b1000);
    look("R5", 19'h01002, 1, 1, 1, 0, 19'h00400);
    look("R6", 19'h01002, 0, 0, 0, 1, '0);
  endtask

  task automatic t_overlap();
    do_reset();
    install(19'h02003, 19'h00111, 0, 4'hF);
    install(19'h02007, 19'h00222, 0, 4'hF);
    install(19'h02010, 19'h00333, 0, 4'hF);
    install(19'h02000, 19'h04000, 1, 4'hF);
    look("R7", 19'h02003, 0, 0, 1, 0, 19'h04003);
    look("R7", 19'h02007, 0, 0, 1, 0, 19'h04007);
    look("R7", 19'h02010, 0, 0, 1, 0, 19'h00333);
    install(19'h02005, 19'h00555, 0, 4'hF);
    look("R7", 19'h02005, 0, 0, 1, 0, 19'h00555);
    look("R7", 19'h02003, 0, 0, 0, 0, '0);
    look("R7", 19'h02010, 0, 0, 1, 0, 19'h00333);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 5; i++) install(19'h00100 + 19'(i), 19'h00A00 + 19'(i), 0, 4'hF);
    look("R8", 19'h00100, 0, 0, 0, 0, '0);
    look("R8", 19'h00101, 0, 0, 1, 0, 19'h00A01);
    look("R8", 19'h00104, 0, 0, 1, 0, 19'h00A04);
    install(19'h00105, 19'h00A05, 0, 4'hF);
    look("R8", 19'h00101, 0, 0, 0, 0, '0);
    look("R8", 19'h00102, 0, 0, 1, 0, 19'h00A02);
    do_reset();
    install(19'h00200, 19'h00B00, 0, 4'hF);
    invalidate(19'h00200);
    for (int i = 1; i < 6; i++) install(19'h00200 + 19'(i), 19'h00B00 + 19'(i), 0, 4'hF);
    look("R8", 19'h00201, 0, 0, 0, 0, '0);
    look("R8", 19'h00204, 0, 0, 1, 0, 19'h00B04);
    look("R8", 19'h00205, 0, 0, 1, 0, 19'h00B05);
  endtask

  task automatic t_inv();
    do_reset();
    install(19'h00300, 19'h00010, 0, 4'hF);
    install(19'h00320, 19'h00040, 1, 4'hF);
    invalidate(19'h0032A);
    look("R9", 19'h00320, 0, 0, 0, 0, '0);
    look("R9", 19'h00300, 0, 0, 1, 0, 19'h00010);
    invalidate(19'h00301);
    look("R9", 19'h00300, 0, 0, 1, 0, 19'h00010);
    invalidate(19'h00300);
    look("R9", 19'h00300, 0, 0, 0, 0, '0);
  endtask

  task automatic t_same();
    do_reset();
    install(19'h00400, 19'h00011, 0, 4'hF);
    @(negedge clk_i);
    ins_i = 1; ins_vpn_i = 19'h00400; ins_ppn_i = 19'h00099; ins_super_i = 0; ins_perm_i = 4'hF;
    inv_i = 1; inv_vpn_i = 19'h00400;
    @(negedge clk_i);
    ins_i = 0; inv_i = 0;
    look("R11", 19'h00400, 0, 0, 1, 0, 19'h00099);
    @(negedge clk_i);
    ins_i = 1; ins_vpn_i = 19'h00500; ins_ppn_i = 19'h00055;
    inv_i = 1; inv_vpn_i = 19'h00400;
    @(negedge clk_i);
    ins_i = 0; inv_i = 0;
    look("R11", 19'h00400, 0, 0, 0, 0, '0);
    look("R11", 19'h00500, 0, 0, 1, 0, 19'h00055);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_base();
    t_super();
    t_perm();
    t_overlap();
    t_rr();
    t_inv();
    t_same();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule